// File: doc/BRIEF.md
# Recovered-Strobe Transmit Clock Generator with Phase Realignment

This block builds the local transmit clock from the strobe that the deserializer recovers, so that both directions of a serial link share one system clock. In single-word mode the recovered strobe goes straight through as the transmit strobe. In double-word mode the strobe runs at twice the word rate, so a divide-by-two flip-flop produces the transmit strobe.

A divider started from an arbitrary edge may settle on the wrong phase. Acquisition therefore has two phases. First, both ends of the link must report lock for a programmable number of strobe cycles, and the frame-phase flag is ignored during this time. Next, the flag is sampled once. If it reports the wrong phase, the divider skips one toggle. That shift breaks lock on purpose, and acquisition starts again. Once the phase is accepted, the link is declared ready and the transmitter handshake opens. Both ends must be set to the same frequency range, but their clocks need not be identical.

Top module: `strobe_realigner`

## Requirements
- R1: While `rst_n` is low at a rising edge of `rx_strobe`, the block clears `link_ready`, `rdy_for_data` and the divider. `data_valid_n` reads 1 and, with `double_mode` = 1, `tx_strobe` reads 0.
- R2: With `double_mode` = 0, `tx_strobe` follows `rx_strobe` with no register in the path.
- R3: With `double_mode` = 1, `tx_strobe` toggles on every rising edge of `rx_strobe`, except on the one slip edge of R5.
- R4: Suppose `near_lock` and `far_lock` are both held high for SETTLE_CYCLES rising edges, and no slip occurs. Then `link_ready` rises on the next edge, which is edge SETTLE_CYCLES+1. It stays low before that edge.
- R5: With `double_mode` = 1, suppose `phase_flag` is high on the phase-check edge (edge SETTLE_CYCLES+1). Then the divider holds its value on the following edge and `link_ready` stays low. The settle count restarts from zero after that edge, so readiness comes SETTLE_CYCLES+1 edges after the slip at the earliest.
- R6: With `double_mode` = 0, `phase_flag` has no effect. `link_ready` still rises on edge SETTLE_CYCLES+1.
- R7: If either lock input is low at a rising edge, `link_ready` is low after that edge, and the settle count starts again from zero.
- R8: `rdy_for_data` equals `link_ready`, and `data_valid_n` is always the inverse of `rdy_for_data`.
- R9: A high `phase_flag` while the link is ready causes no slip. The divider keeps toggling and `link_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_strobe | input | 1 | Recovered receive strobe; clocks all state |
| rst_n | input | 1 | Synchronous reset, active low |
| double_mode | input | 1 | 1 = double-word mode (divide by two), 0 = single-word mode |
| near_lock | input | 1 | Local deserializer reports lock |
| far_lock | input | 1 | Remote side reports lock |
| phase_flag | input | 1 | 1 = divided clock is on the wrong phase |
| tx_strobe | output | 1 | Transmit strobe to the serializer |
| link_ready | output | 1 | Both sides locked and phase accepted |
| rdy_for_data | output | 1 | Ready-for-data to the transmitter |
| data_valid_n | output | 1 | Data-valid to the transmitter, inverse of `rdy_for_data` |

## Verification
A sequencer stuck in a wrong state shows at the ports within one strobe edge. A missed return to acquisition keeps `link_ready` high one edge after a lock input drops. A missing slip shows as `tx_strobe` failing to repeat its level on the sample after the phase check. A settle counter off by one moves the rise of `link_ready` by exactly one edge against the expected edge SETTLE_CYCLES+1. A divider that skips toggles outside the slip edge breaks the alternation of `tx_strobe` at the very next sample.

// File: rtl/strobe_realigner.sv
module strobe_realigner #(
  parameter int SETTLE_CYCLES = 16
) (
  input  logic rx_strobe,
  input  logic rst_n,
  input  logic double_mode,
  input  logic near_lock,
  input  logic far_lock,
  input  logic phase_flag,
  output logic tx_strobe,
  output logic link_ready,
  output logic rdy_for_data,
  output logic data_valid_n
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {ACQUIRE = 2'd0, CHECK_PHASE = 2'd1, SLIP = 2'd2, READY = 2'd3} seq_t;

  seq_t             state, state_nx;
  logic [CNT_W-1:0] cnt;
  logic             div_q;
  logic             both_lock;
  logic             counting;

  assign both_lock = near_lock & far_lock;
  assign counting  = (state == ACQUIRE) && both_lock;

  always_comb begin
    state_nx = state;
    if (!both_lock) begin
      state_nx = ACQUIRE;
    end else begin
      case (state)
        ACQUIRE:     if (cnt == CNT_LAST) state_nx = CHECK_PHASE;
        CHECK_PHASE: state_nx = (double_mode && phase_flag) ? SLIP : READY;
        SLIP:        state_nx = ACQUIRE;
        default:     state_nx = READY;
      endcase
    end
  end

  always_ff @(posedge rx_strobe) begin
    if (!rst_n) begin
      state <= ACQUIRE;
      cnt   <= '0;
      div_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (counting && cnt != CNT_LAST) cnt <= cnt + 1'b1;
      else if (!counting)              cnt <= '0;
      if (state != SLIP) div_q <= ~div_q;
    end
  end

  assign tx_strobe    = double_mode ? div_q : rx_strobe;
  assign link_ready   = (state == READY);
  assign rdy_for_data = link_ready;
  assign data_valid_n = ~rdy_for_data;
endmodule

module strobe_realigner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       double_mode,
  input logic       near_lock,
  input logic       far_lock,
  input logic       link_ready,
  input logic       rdy_for_data,
  input logic       data_valid_n,
  input logic       div_q,
  input logic [1:0] st
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    !rst_n |=> (!link_ready && !div_q));

  assert_toggle_when_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_ready |=> (div_q != $past(div_q)));

  assert_ready_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ready) |-> $past(near_lock && far_lock));

  assert_slip_holds_divider_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2) |=> ((div_q == $past(div_q)) && !link_ready));

  assert_single_no_slip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!double_mode && $past(!double_mode)) |-> (st != 2'd2));

  assert_unlock_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(near_lock && far_lock) |=> !link_ready);

  assert_handshake_inverse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid_n == !rdy_for_data) && (rdy_for_data == link_ready));
endmodule

bind strobe_realigner strobe_realigner_chk u_chk (
  .clk          (rx_strobe),
  .rst_n        (rst_n),
  .double_mode  (double_mode),
  .near_lock    (near_lock),
  .far_lock     (far_lock),
  .link_ready   (link_ready),
  .rdy_for_data (rdy_for_data),
  .data_valid_n (data_valid_n),
  .div_q        (div_q),
  .st           (state)
);

// File: tb/strobe_realigner_bench.sv
module strobe_realigner_bench;
  localparam int SETTLE = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic double_mode = 1'b0;
  logic near_lock = 1'b0;
  logic far_lock = 1'b0;
  logic phase_flag = 1'b0;
  logic tx_strobe, link_ready, rdy_for_data, data_valid_n;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  strobe_realigner #(.SETTLE_CYCLES(SETTLE)) u_strobe_realigner (
    .rx_strobe(clk), .rst_n(rst_n), .double_mode(double_mode),
    .near_lock(near_lock), .far_lock(far_lock), .phase_flag(phase_flag),
    .tx_strobe(tx_strobe), .link_ready(link_ready),
    .rdy_for_data(rdy_for_data), .data_valid_n(data_valid_n));

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic chk_hs(input string tag);
    chk({tag, " R8 rfd"}, rdy_for_data, link_ready);
    chk({tag, " R8 dav_n"}, data_valid_n, ~rdy_for_data);
  endtask

  task automatic do_reset(input logic dm);
    rst_n = 1'b0; near_lock = 1'b0; far_lock = 1'b0; phase_flag = 1'b0;
    double_mode = dm;
    repeat (3) @(negedge clk);
    chk("R1 link_ready", link_ready, 1'b0);
    chk("R1 rdy_for_data", rdy_for_data, 1'b0);
    chk("R1 data_valid_n", data_valid_n, 1'b1);
    if (dm) chk("R1 tx_strobe", tx_strobe, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic t_single;
    do_reset(1'b0);
    phase_flag = 1'b1;
    near_lock = 1'b1; far_lock = 1'b1;
    repeat (SETTLE) @(negedge clk);
    chk("R4 single early", link_ready, 1'b0);
    @(negedge clk);
    chk("R6 single flag ignored", link_ready, 1'b1);
    chk_hs("single ready");
    chk("R2 tx low", tx_strobe, 1'b0);
    @(posedge clk); #1;
    chk("R2 tx high", tx_strobe, 1'b1);
    @(negedge clk);
    chk("R2 tx low again", tx_strobe, 1'b0);
    phase_flag = 1'b0;
  endtask

  task automatic t_double;
    logic prev;
    do_reset(1'b1);
    near_lock = 1'b1; far_lock = 1'b1;
    prev = tx_strobe;
    for (int i = 1; i <= SETTLE + 1; i++) begin
      @(negedge clk);
      chk("R3 alternation", tx_strobe, ~prev);
      prev = tx_strobe;
      if (i == SETTLE) chk("R4 double early", link_ready, 1'b0);
    end
    chk("R4 double ready", link_ready, 1'b1);
    chk_hs("double ready");
  endtask

  task automatic t_flag_ready;
    logic prev;
    phase_flag = 1'b1;
    prev = tx_strobe;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R9 toggle in ready", tx_strobe, ~prev);
      chk("R9 still ready", link_ready, 1'b1);
      prev = tx_strobe;
    end
    phase_flag = 1'b0;
  endtask

  task automatic t_lock_drop;
    far_lock = 1'b0;
    @(negedge clk);
    chk("R7 ready drops", link_ready, 1'b0);
    chk_hs("unlocked");
    far_lock = 1'b1;
    repeat (SETTLE / 2) @(negedge clk);
    near_lock = 1'b0;
    @(negedge clk);
    near_lock = 1'b1;
    repeat (SETTLE) @(negedge clk);
    chk("R7 count restarted", link_ready, 1'b0);
    @(negedge clk);
    chk("R7 ready after restart", link_ready, 1'b1);
  endtask

  task automatic t_slip;
    logic exp;
    do_reset(1'b1);
    phase_flag = 1'b1;
    near_lock = 1'b1; far_lock = 1'b1;
    exp = 1'b0;
    for (int i = 1; i <= 2 * SETTLE + 3; i++) begin
      @(negedge clk);
      if (i != SETTLE + 2) exp = ~exp;
      chk("R5 divider sequence", tx_strobe, exp);
      chk("R5 ready timing", link_ready, (i == 2 * SETTLE + 3));
      if (i == SETTLE + 2) phase_flag = 1'b0;
    end
    chk_hs("after slip");
  endtask

  initial begin
    t_single();
    t_double();
    t_flag_ready();
    t_lock_drop();
    t_slip();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule